// File: doc/BRIEF.md
# Misaligned Data Access Splitter

This block sits between a load/store unit and a 32-bit little-endian data bus with byte addressing. It takes one load or store of byte, halfword or word size at any byte address. It turns that access into one or more aligned bus transfers. For a load, it gathers the returned bytes into one right-aligned response. Sign or zero extension of a loaded value is left to the load/store unit.

The block has two splitting configurations, selected by a static strap input. The strap is sampled when a request is accepted. In the strobed configuration, an access that crosses a word boundary becomes two transfers: one in each word, each with byte strobes. In the narrow configuration, the access is cut into naturally aligned byte and halfword pieces, with at most three pieces. An access that is already aligned always goes out as a single transfer.

The bus side has one transfer in flight at a time. A piece is requested and held until it is granted. The next piece is requested only after the current piece has returned its response.

Top module: `misalign_splitter`

## Requirements
- R1: After reset, `req_ready` is 1 and both `bus_req` and `rsp_valid` are 0.
- R2: An access whose address is a multiple of its size (size code 0 = byte, 1 = halfword, 2 = word) is issued as exactly one transfer in either configuration, with strobes covering only its own bytes.
- R3: With `cfg_narrow` = 0, an access that crosses a word boundary is issued as exactly two transfers. The first covers its bytes up to the end of the first word and the second covers the rest, starting at lane 0.
- R4: With `cfg_narrow` = 1, every transfer is a naturally aligned byte, halfword or (only for an aligned word) word, and no access uses more than three transfers. A word at offset 2 becomes halfword, halfword. A word at offset 1 or 3 becomes byte, halfword, byte.
- R5: The pieces of one access are issued in ascending address order. `bus_addr` is the byte address of the piece's lowest byte. Strobe bit j marks the byte at the word-aligned base of `bus_addr` plus j.
- R6: On a store, each strobed lane of `bus_wdata` carries the request byte that belongs to that address. Request byte i (bits 8i+7:8i of `req_wdata`) belongs to address `req_addr`+i.
- R7: A load's response is given once, as a one-cycle `rsp_valid` pulse after the last piece completes. Byte i of `rsp_rdata` holds the byte read at `req_addr`+i, and bytes at or above the access size are zero.
- R8: If any piece completes with `bus_err` high, `rsp_err` is 1 on the response. No piece is retried, so the number of transfers is unchanged.
- R9: `req_ready` stays 0 from the accepting edge until the response has been given, so no new request is taken while pieces are outstanding.
- R10: The configuration used for an access is the value of `cfg_narrow` at acceptance. Changes to it while the access is in progress have no effect on that access.
- R11: While `bus_req` is high and `bus_gnt` is low, the request and its address, strobes and write data stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_narrow | input | 1 | Splitting configuration: 0 strobed words, 1 byte/halfword pieces |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | AW | Byte address of the access |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Some piece reported an error |
| rsp_rdata | output | 32 | Merged load data, right-aligned |
| bus_req | output | 1 | Transfer request |
| bus_gnt | input | 1 | Transfer accepted |
| bus_addr | output | AW | Byte address of the piece |
| bus_we | output | 1 | Transfer is a write |
| bus_be | output | 4 | Byte lane strobes |
| bus_wdata | output | 32 | Lane-placed write data |
| bus_rvalid | input | 1 | Transfer response |
| bus_rdata | input | 32 | Read data of the word |
| bus_err | input | 1 | Transfer error |

## Verification
The hardest case to reach from the ports is an error on a middle piece of a three-piece narrow access. The same difficulty applies to a grant that is withheld while the configuration strap changes under an access in progress. The bench bus model withholds grants and delays responses at random, and it injects an error on a chosen piece index. The strap is scrambled on every cycle after acceptance. Directed sweeps cover every size and offset in both configurations, including a word that wraps past the top of the address space. Random accesses then mix these conditions, and each load is compared against a reference byte memory kept by the bench.

// File: rtl/misalign_splitter.sv
module misalign_splitter #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_narrow,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [31:0]   rsp_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic          bus_we,
  output logic [3:0]    bus_be,
  output logic [31:0]   bus_wdata,
  input  logic          bus_rvalid,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_err
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_t;

  st_t          st;
  logic [AW-1:0] a_q;
  logic [1:0]   sz_q;
  logic         we_q, nar_q, err_q;
  logic [31:0]  wd_q, acc_q;
  logic [2:0]   k_q;
  logic [1:0]   pc_q;

  logic [2:0]   nb, rem, room, len_w, len_n, len;
  logic [AW-1:0] cur;
  logic [3:0]   lmask;
  logic [31:0]  bmask, piece;
  logic [4:0]   lane_sh, k_sh;
  logic         last;

  assign nb      = (sz_q == 2'd0) ? 3'd1 : (sz_q == 2'd1) ? 3'd2 : 3'd4;
  assign cur     = a_q + AW'(k_q);
  assign rem     = nb - k_q;
  assign room    = 3'd4 - {1'b0, cur[1:0]};
  assign len_w   = (rem < room) ? rem : room;
  assign len_n   = cur[0] ? 3'd1 :
                   (cur[1] == 1'b0 && rem == 3'd4) ? 3'd4 :
                   (rem >= 3'd2) ? 3'd2 : 3'd1;
  assign len     = nar_q ? len_n : len_w;
  assign lmask   = (len == 3'd1) ? 4'h1 : (len == 3'd2) ? 4'h3 :
                   (len == 3'd3) ? 4'h7 : 4'hf;
  assign bmask   = {{8{lmask[3]}}, {8{lmask[2]}}, {8{lmask[1]}}, {8{lmask[0]}}};
  assign lane_sh = {cur[1:0], 3'b000};
  assign k_sh    = {k_q[1:0], 3'b000};
  assign piece   = (bus_rdata >> lane_sh) & bmask;
  assign last    = (k_q + len) == nb;

  assign req_ready = (st == S_IDLE);
  assign bus_req   = (st == S_ISSUE);
  assign bus_addr  = cur;
  assign bus_we    = we_q;
  assign bus_be    = lmask << cur[1:0];
  assign bus_wdata = (wd_q >> k_sh) << lane_sh;
  assign rsp_valid = (st == S_DONE);
  assign rsp_err   = err_q;
  assign rsp_rdata = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      a_q   <= '0;
      sz_q  <= '0;
      we_q  <= 1'b0;
      nar_q <= 1'b0;
      wd_q  <= '0;
      acc_q <= '0;
      err_q <= 1'b0;
      k_q   <= '0;
      pc_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          a_q   <= req_addr;
          sz_q  <= req_size;
          we_q  <= req_write;
          nar_q <= cfg_narrow;
          wd_q  <= req_wdata;
          acc_q <= '0;
          err_q <= 1'b0;
          k_q   <= '0;
          pc_q  <= '0;
          st    <= S_ISSUE;
        end
        S_ISSUE: if (bus_gnt) st <= S_WAIT;
        S_WAIT: if (bus_rvalid) begin
          acc_q <= acc_q | (piece << k_sh);
          err_q <= err_q | bus_err;
          k_q   <= k_q + len;
          pc_q  <= pc_q + 2'd1;
          st    <= last ? S_DONE : S_ISSUE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_be) && $stable(bus_wdata)); // R11

  AST_WORD_TWO_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !nar_q |-> pc_q <= 2'd1); // R3

  AST_NARROW_THREE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && nar_q |-> pc_q <= 2'd2); // R4

  AST_NARROW_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && nar_q |-> ($countones(bus_be) == 1) || (bus_be == 4'h3) ||
                         (bus_be == 4'hc) || (bus_be == 4'hf)); // R4

  AST_RSP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_rvalid)); // R7

endmodule

// File: tb/misalign_splitter_bench.sv
module misalign_splitter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_narrow = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_size = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic bus_req, bus_we;
  logic bus_gnt, bus_rvalid, bus_err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0] bus_be;

  always #4 clk = ~clk;

  misalign_splitter u_misalign_splitter (
    .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .bus_err(bus_err));

  int checks = 0, fails = 0;
  logic [7:0] mem [64];
  logic [7:0] ref_m [64];
  logic [31:0] pa [8];
  logic [3:0]  pb [8];
  int np = 0;
  logic [31:0] ea [8];
  logic [3:0]  eb [8];
  int en = 0;
  int err_sel = 9;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected pieces from the splitting rules
  task automatic plan(input bit nar, input logic [1:0] sz, input logic [31:0] ad);
    int n = 1 << sz;
    int i = 0;
    en = 0;
    while (i < n) begin
      logic [31:0] a = ad + i;
      int r = n - i;
      int len = 0;
      if (!nar) begin
        len = 4 - int'(a[1:0]);
        if (len > r) len = r;
      end else begin
        if (r >= 4 && a[1:0] == 2'd0) len = 4;
        else if (r >= 2 && a[0] == 1'b0) len = 2;
        else len = 1;
      end
      ea[en] = a;
      eb[en] = 4'(((1 << len) - 1) << a[1:0]);
      en++;
      i += len;
    end
  endtask

  // bus responder
  initial begin
    bit ph = 0, held = 0;
    int dly = 0;
    logic [31:0] cap = '0, h_addr = '0;
    logic [3:0] h_be = '0;
    bus_gnt = 0; bus_rvalid = 0; bus_err = 0; bus_rdata = '0;
    forever begin
      @(negedge clk);
      bus_gnt = 0; bus_rvalid = 0; bus_err = 0;
      if (!rst_n) begin
        ph = 0; held = 0;
      end else if (!ph) begin
        if (bus_req) begin
          if (held) chk(bus_addr == h_addr && bus_be == h_be, "R11 held request", bus_addr, h_addr);
          if ($urandom_range(0, 2) != 0) begin
            bus_gnt = 1; held = 0;
            if (np < 8) begin pa[np] = bus_addr; pb[np] = bus_be; end
            np++;
            if (bus_we)
              for (int j = 0; j < 4; j++)
                if (bus_be[j]) mem[6'(bus_addr[31:2] * 4 + j)] = bus_wdata[8*j +: 8];
            cap = bus_addr; ph = 1; dly = $urandom_range(0, 2);
          end else begin
            held = 1; h_addr = bus_addr; h_be = bus_be;
          end
        end
      end else begin
        if (dly == 0) begin
          for (int j = 0; j < 4; j++) bus_rdata[8*j +: 8] = mem[6'(cap[31:2] * 4 + j)];
          bus_rvalid = 1;
          bus_err = (np - 1 == err_sel);
          ph = 0;
        end else dly--;
      end
    end
  end

  task automatic do_req(input bit we, input logic [1:0] sz, input logic [31:0] ad,
                        input logic [31:0] wd, input bit nar, input int esel, input string dtag);
    int n = 1 << sz;
    bit busy_bad = 0;
    bit aligned = (ad % n) == 0;
    string ptag = aligned ? "R2" : (nar ? "R4" : "R3");
    logic [31:0] exp_d = '0;
    plan(nar, sz, ad);
    np = 0; err_sel = esel;
    @(negedge clk);
    req_valid = 1; req_write = we; req_size = sz; req_addr = ad; req_wdata = wd; cfg_narrow = nar;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_addr = $urandom; req_wdata = $urandom; req_write = $urandom;
    while (!rsp_valid) begin
      if (req_ready) busy_bad = 1;
      cfg_narrow = $urandom; // R10: strap scrambled during the access
      @(negedge clk);
    end
    chk(!busy_bad, "R9 ready low while busy", 32'(busy_bad), 0);
    chk(np == en, {ptag, " R10 piece count"}, np, en);
    for (int p = 0; p < en && p < np; p++) begin
      chk(pa[p] == ea[p], "R5 piece address", pa[p], ea[p]);
      chk(pb[p] == eb[p], {ptag, " piece strobes"}, 32'(pb[p]), 32'(eb[p]));
    end
    chk(rsp_err == (esel < en), "R8 error merge", 32'(rsp_err), 32'(esel < en));
    if (we) begin
      for (int i = 0; i < n; i++) ref_m[6'(ad + i)] = wd[8*i +: 8];
    end else begin
      for (int i = 0; i < n; i++) exp_d[8*i +: 8] = ref_m[6'(ad + i)];
      chk(rsp_rdata == exp_d, dtag, rsp_rdata, exp_d);
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 64; i++) begin mem[i] = 8'($urandom); ref_m[i] = mem[i]; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !bus_req && !rsp_valid, "R1 reset state",
        {29'd0, req_ready, bus_req, rsp_valid}, 32'h4);
    for (int nar = 0; nar < 2; nar++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off++) begin
          do_req(1, 2'(sz), 32'h20 + off, $urandom, nar[0], 9, "R6 store");
          do_req(0, 2'(sz), 32'h20 + off, 0, nar[0], 9, "R6 R7 load back");
        end
    do_req(1, 2'd2, 32'hffff_fffe, 32'h1122_3344, 1'b0, 9, "R6 wrap store");
    do_req(0, 2'd2, 32'hffff_fffe, 0, 1'b1, 9, "R7 wrap load");
    do_req(0, 2'd2, 32'h0000_0031, 0, 1'b1, 1, "R7 middle error load");
    do_req(0, 2'd2, 32'h0000_0033, 0, 1'b0, 1, "R7 second error load");
    do_req(1, 2'd1, 32'h0000_0013, $urandom, 1'b1, 0, "R6 error store");
    for (int t = 0; t < 400; t++)
      do_req($urandom_range(0, 1) == 1, 2'($urandom_range(0, 2)), $urandom, $urandom,
             $urandom_range(0, 1) == 1, $urandom_range(0, 5), "R7 random load");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule